// File: doc/BRIEF.md
# NMI Gating Controller for System-Management Mode

This controller sits between the external non-maskable interrupt request line and the point where the core takes interrupts. It tracks whether an NMI may be delivered at the moment. It holds one pending request and a blocked flag. It also records whether the core is inside system-management mode, and keeps one saved copy of the blocked flag taken when that mode is entered.

Entering system-management mode blocks NMIs at once. Requests that arrive while NMIs are blocked are held, and any number of them merge into one pending request. An interrupt-return can lift the block early, even inside the handler. Resume puts back the blocking state recorded at entry. A parameter chooses whether blocking set by an NMI handler that was running at entry is kept in the saved copy. By default it is not kept, so a second NMI can follow resume even though the earlier handler has not finished.

The core raises `nmi_dlv` only on instruction-boundary cycles. It takes the interrupt by asserting `dlv_ack` in that same cycle.

Top module: `nmi_smm_gate`

## Requirements
- R1: A cycle with `smm_enter` high while outside system-management mode blocks NMIs from the next cycle on, whatever the earlier state was.
- R2: A request (`nmi_req` high for one cycle) that arrives while NMIs are blocked is held as pending and is not dropped.
- R3: At most one request is pending. Further requests that arrive while one is pending merge into it, and a single delivery clears it.
- R4: On resume (`smm_resume` high while inside the mode), if the saved copy says NMIs were not blocked, the block is lifted and a pending request is delivered at the first boundary after resume.
- R5: With `KEEP_HANDLER_BLOCK`=1, NMIs that were blocked at entry stay blocked after resume, and a held request stays pending until an interrupt-return.
- R6: `iret` lifts the block, also inside system-management mode. From the next cycle on, NMIs are delivered normally before resume.
- R7: With the default `KEEP_HANDLER_BLOCK`=0, blocking set by an NMI delivery before entry is not saved, so resume can deliver a new NMI while the earlier handler is still running.
- R8: A delivery (`nmi_dlv` and `dlv_ack` both high) clears pending and sets the block. The block holds until the next `iret`, entry or resume.
- R9: A request that arrives in the same cycle as a delivery leaves pending set afterwards.
- R10: `smm_enter` while already inside system-management mode is ignored. The saved copy is not captured again.
- R11: Reset clears the pending, blocked, in-mode and saved state, so `nmi_pend` and `nmi_dlv` are 0 after reset.
- R12: `nmi_dlv` is high only in a cycle where `insn_bdry` is high, a request is pending and NMIs are not blocked. Without `dlv_ack`, the request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_req | input | 1 | NMI request pulse |
| smm_enter | input | 1 | System-management entry strobe |
| smm_resume | input | 1 | Resume strobe |
| iret | input | 1 | Interrupt-return strobe |
| insn_bdry | input | 1 | Instruction-boundary strobe |
| dlv_ack | input | 1 | Core takes the offered NMI this cycle |
| nmi_dlv | output | 1 | NMI delivery request (combinational from state and boundary) |
| nmi_pend | output | 1 | A request is pending |

## Verification
The assertions check on every cycle the effects that show within one clock:
- no delivery is offered in the cycle after an entry or after an acknowledged delivery (unless `iret` or resume intervenes),
- a request always leaves pending set,
- an acknowledged delivery with no new request clears pending,
- after an `iret`, nothing pending stays undelivered at a boundary.

Only the bench's scenarios can show the effects that span several cycles:
- the save and restore of blocking across entry and resume under both parameter settings,
- a nested entry leaving the saved copy alone,
- several requests merging into one delivery.

// File: rtl/nmi_smm_gate.sv
module nmi_smm_gate #(
  parameter bit KEEP_HANDLER_BLOCK = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_req,
  input  logic smm_enter,
  input  logic smm_resume,
  input  logic iret,
  input  logic insn_bdry,
  input  logic dlv_ack,
  output logic nmi_dlv,
  output logic nmi_pend
);

  logic pend_q, blk_q, in_smm_q, saved_q;
  logic take, enter_ok, resume_ok;

  assign enter_ok  = smm_enter && !in_smm_q;
  assign resume_ok = smm_resume && in_smm_q;
  assign nmi_dlv   = insn_bdry && pend_q && !blk_q;
  assign take      = nmi_dlv && dlv_ack;
  assign nmi_pend  = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      blk_q    <= 1'b0;
      in_smm_q <= 1'b0;
      saved_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q && !take) || nmi_req;
      if (enter_ok) begin
        in_smm_q <= 1'b1;
        saved_q  <= KEEP_HANDLER_BLOCK ? blk_q : 1'b0;
        blk_q    <= 1'b1;
      end else if (resume_ok) begin
        in_smm_q <= 1'b0;
        blk_q    <= saved_q;
      end else if (iret) begin
        blk_q <= 1'b0;
      end else if (take) begin
        blk_q <= 1'b1;
      end
    end
  end

  // R1
  entry_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_ok |=> !nmi_dlv);

  // R2
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> nmi_pend);

  // R3
  single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !nmi_req) |=> !nmi_pend);

  // R8
  dlv_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !iret && !resume_ok && !enter_ok) |=> !nmi_dlv);

  // R6
  iret_unblocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iret && !enter_ok && !resume_ok) |=> (!(insn_bdry && nmi_pend) || nmi_dlv));

  // R12
  dlv_bdry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_dlv |-> (insn_bdry && nmi_pend));

endmodule

// File: tb/nmi_smm_gate_tb.sv
module nmi_smm_gate_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_req = 0, smm_enter = 0, smm_resume = 0, iret = 0, insn_bdry = 0, dlv_ack = 0;
  logic d0, p0, d1, p1;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  nmi_smm_gate dut_i (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .smm_enter(smm_enter),
    .smm_resume(smm_resume), .iret(iret), .insn_bdry(insn_bdry), .dlv_ack(dlv_ack),
    .nmi_dlv(d0), .nmi_pend(p0));

  nmi_smm_gate #(.KEEP_HANDLER_BLOCK(1'b1)) dut_keep (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .smm_enter(smm_enter),
    .smm_resume(smm_resume), .iret(iret), .insn_bdry(insn_bdry), .dlv_ack(dlv_ack),
    .nmi_dlv(d1), .nmi_pend(p1));

  // {req, enter, resume, iret, bdry, ack, exp dlv/pend default, exp dlv/pend keep}
  localparam int NV = 24;
  localparam logic [9:0] VEC [NV] = '{
    10'b000010_00_00, 10'b100000_00_00, 10'b000011_11_11, 10'b100010_00_00,
    10'b000010_01_01, 10'b010010_01_01, 10'b100010_01_01, 10'b001010_01_01,
    10'b000011_11_01, 10'b000100_00_01, 10'b000011_00_11, 10'b000100_00_00,
    10'b010000_00_00, 10'b100010_00_00, 10'b000010_01_01, 10'b000110_01_01,
    10'b100011_11_11, 10'b000010_01_01, 10'b010010_01_01, 10'b001000_01_01,
    10'b000000_01_01, 10'b000010_11_11, 10'b000011_11_11, 10'b000010_00_00
  };

  function automatic string tag(int i);
    case (i)
      0: return "R12";  1: return "R12";  2: return "R8";   3: return "R8";
      4: return "R2";   5: return "R1";   6: return "R3";   7: return "R4";
      8: return "R7";   9: return "R5";   10: return "R5";  11: return "R8";
      12: return "R1";  13: return "R2";  14: return "R2";  15: return "R6";
      16: return "R9";  17: return "R9";  18: return "R10"; 19: return "R10";
      20: return "R12"; 21: return "R12"; 22: return "R4";  default: return "R3";
    endcase
  endfunction

  task automatic chk(string r, logic [1:0] act, logic [1:0] exp, string who);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: dlv/pend actual %b expected %b", r, who, act, exp);
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R11", {d0, p0}, 2'b00, "default");
    chk("R11", {d1, p1}, 2'b00, "keep");
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {nmi_req, smm_enter, smm_resume, iret, insn_bdry, dlv_ack} = VEC[i][9:4];
      #1;
      chk(tag(i), {d0, p0}, VEC[i][3:2], "default");
      chk(tag(i), {d1, p1}, VEC[i][1:0], "keep");
    end
    // R11: reset in the middle of a held request inside the mode
    @(negedge clk);
    {nmi_req, smm_enter, smm_resume, iret, insn_bdry, dlv_ack} = 6'b110000;
    @(negedge clk);
    {nmi_req, smm_enter, smm_resume, iret, insn_bdry, dlv_ack} = 6'b000010;
    #1;
    chk("R11", {d0, p0}, 2'b01, "default pre-reset");
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R11", {d0, p0}, 2'b00, "default after reset");
    chk("R11", {d1, p1}, 2'b00, "keep after reset");
    // R11: in-mode flag cleared, so a fresh request is delivered without resume
    {nmi_req, smm_enter, smm_resume, iret, insn_bdry, dlv_ack} = 6'b100000;
    @(negedge clk);
    {nmi_req, smm_enter, smm_resume, iret, insn_bdry, dlv_ack} = 6'b000011;
    #1;
    chk("R11", {d0, p0}, 2'b11, "default unblocked after reset");
    @(negedge clk);
    {nmi_req, smm_enter, smm_resume, iret, insn_bdry, dlv_ack} = 6'b000000;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule